// File: doc/BRIEF.md
# Descriptor-Driven Conversion Sequencer

This block decides when an external analog-to-digital converter starts each conversion. Software loads a table of eight conversion descriptors. A trigger starts the sequence. The trigger can come from a software write or from one of several hardware inputs. After the trigger, the block walks the table. A pacing counter advances once per converter clock. When that counter reaches the match value of the current descriptor, the block emits a conversion strobe for one cycle. The strobe carries the descriptor's channel number and its threshold-register select. The converter and the result comparison logic sit downstream. They use these two fields, and the sequencer never looks at them again.

Each descriptor also states what happens after it fires:

- **Advance** moves to the next table entry. After the last entry it wraps to entry 0.
- **Halt** returns the block to idle, where it waits for a fresh trigger.
- **Clear-timer flag:** when set, the pacing counter restarts after the conversion, so every conversion is spaced by its own match value. When clear, the counter keeps running, so match values act as absolute times measured from the trigger.

The control machine has two states:

- **IDLE:** waiting for a trigger.
- **RUN:** pacing conversions.

It has four transitions:

- **IDLE→RUN (start):** a trigger is seen while idle. The index and counter are loaded.
- **RUN→RUN (wait):** no match yet. The counter ticks.
- **RUN→RUN (advance):** a match on an advancing descriptor. The index steps forward.
- **RUN→IDLE (halt):** a match on a halting descriptor.

Top module: `conv_sequencer`

## Requirements
- R1: A table write (`cfg_we` high) stores `cfg_data` into entry `cfg_idx`. The eight entries use this field layout:
  - bits [13:11]: channel
  - bits [10:3]: match value
  - bit 2: action, where 1 means advance and 0 means halt
  - bit 1: clear-timer flag
  - bit 0: threshold select
- R2: While idle, a cycle with `trig_wr` high and `trig_bit` high starts a sequence at entry 0. A cycle with `trig_wr` high and `trig_bit` low has no effect, and `busy` stays low.
- R3: While idle, a high level on `hw_trig[hw_sel]` starts a sequence at entry 0. The other hardware inputs have no effect.
- R4: With a match value M≥1, `conv_strobe` is first seen high M clock cycles after the edge that accepted the trigger. For M=0 this delay is one cycle.
- R5: A match value of 0 issues a conversion on every clock cycle. A chain of match-0 advancing descriptors therefore gives back-to-back strobes, one per entry.
- R6: When the clear-timer flag of the descriptor that fired is set, the next conversion comes M cycles later, where M is the next descriptor's match value. When the flag is clear, the counter keeps counting, and the next conversion comes when the count since the trigger reaches the next match value.
- R7: An advancing descriptor steps the index forward, wrapping from entry 7 to entry 0. A halting descriptor makes `busy` drop in the same cycle its strobe appears.
- R8: Each conversion gives `conv_strobe` high for exactly one cycle. `conv_chan` and `conv_thr_sel` carry the fired descriptor's fields in that same cycle.
- R9: The threshold select never changes when a conversion occurs. Descriptors that differ only in that bit produce the same strobe timing.
- R10: Triggers from any source that arrive while a sequence is running are ignored, and the running sequence keeps its timing.
- R11: After reset, `conv_strobe` and `busy` are low and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; the pacing counter ticks on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor table write strobe |
| cfg_idx | input | 3 | Table entry written |
| cfg_data | input | 14 | Descriptor word (layout in R1) |
| trig_wr | input | 1 | Write to the software trigger register |
| trig_bit | input | 1 | Trigger bit of that write; 1 starts a sequence |
| hw_trig | input | 4 | Hardware trigger inputs |
| hw_sel | input | 2 | Selects which hardware input may start a sequence |
| conv_strobe | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel of the conversion being started |
| conv_thr_sel | output | 1 | Threshold-register select attached to the result |
| busy | output | 1 | High while a sequence is running |

## Verification
The assertions assume three things about the inputs:

- The table is not rewritten while a sequence runs.
- `hw_sel` holds steady around a trigger.
- The pacing counter never wraps past its width before a match is reached.

The stimulus keeps to all three:

- Every descriptor load happens while `busy` is low.
- The hardware select is set well before the pulse that uses it.
- All match values stay well below 256, and the non-clearing case uses a match that increases along the table.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    localparam int CH_W    = 3;
    localparam int MATCH_W = 8;

    typedef struct packed {
        logic [CH_W-1:0]    chan;
        logic [MATCH_W-1:0] match;
        logic               advance;
        logic               clr_timer;
        logic               thr_sel;
    } conv_desc_t;

    localparam int DESC_W = $bits(conv_desc_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/conv_desc_table.sv
module conv_desc_table
    import conv_seq_pkg::*;
#(
    parameter int N_DESC = 8,
    localparam int IDX_W = $clog2(N_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  conv_desc_t       wdata,
    input  logic [IDX_W-1:0] ridx,
    output conv_desc_t       rdata
);
    conv_desc_t entry_q [N_DESC];

    for (genvar g = 0; g < N_DESC; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else if (we && (32'(widx) == g)) begin
                entry_q[g] <= wdata;
            end
        end
    end

    assign rdata = entry_q[ridx];

    // R1: a write lands in the addressed entry on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we && (32'(widx) < N_DESC) |=> entry_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/conv_pace_timer.sv
module conv_pace_timer
    import conv_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic               fire,
    input  logic               reload,
    input  logic               stop,
    output logic [MATCH_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= MATCH_W'(1);
        end else if (stop) begin
            cnt <= '0;
        end else if (run) begin
            if (fire && reload) cnt <= MATCH_W'(1);
            else                cnt <= cnt + 1'b1;
        end
    end

    // R4: each clock of a running sequence advances the count by one
    a_r4_tick: assert property (@(posedge clk) disable iff (!rst_n)
        run && !fire && !start |=> cnt == MATCH_W'($past(cnt) + 1'b1));

    // R6: the clear-timer flag restarts the count after a conversion
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run && fire && reload && !stop |=> cnt == MATCH_W'(1));

    // R2: an accepted trigger starts the count from one
    a_r2_start_count: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt == MATCH_W'(1));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int N_DESC = 8,
    localparam int IDX_W = $clog2(N_DESC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  conv_desc_t         desc,
    input  logic [MATCH_W-1:0] cnt,
    output logic               start,
    output logic               fire,
    output logic               stop,
    output logic [IDX_W-1:0]   idx,
    output logic               busy,
    output logic               conv_strobe,
    output logic [CH_W-1:0]    conv_chan,
    output logic               conv_thr_sel
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DESC - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    assign start = (state_q == ST_IDLE) && start_req;
    assign fire  = (state_q == ST_RUN) &&
                   ((desc.match == '0) || (cnt == desc.match));
    assign stop  = fire && !desc.advance;
    assign idx   = idx_q;
    assign busy  = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_RUN;
                    idx_d   = '0;
                end
            end
            ST_RUN: begin
                if (fire) begin
                    if (desc.advance) begin
                        idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_strobe  <= 1'b0;
            conv_chan    <= '0;
            conv_thr_sel <= 1'b0;
        end else begin
            conv_strobe <= fire;
            if (fire) begin
                conv_chan    <= desc.chan;
                conv_thr_sel <= desc.thr_sel;
            end
        end
    end

    // R8: a match yields a strobe carrying that descriptor's fields
    a_r8_strobe_fields: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> conv_strobe && conv_chan == $past(desc.chan)
                 && conv_thr_sel == $past(desc.thr_sel));

    // R8: strobes only follow a running cycle
    a_r8_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> $past(state_q == ST_RUN));

    // R7: a halting descriptor returns to idle
    a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !desc.advance |=> state_q == ST_IDLE);

    // R7: advancing past the last entry wraps to entry 0
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        fire && desc.advance && idx_q == LAST |=> idx_q == '0);

    // R10: while running with no match, triggers change neither state nor index
    a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && !fire |=> state_q == ST_RUN && idx_q == $past(idx_q));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int N_DESC = 8,
    parameter int HW_N   = 4,
    localparam int IDX_W = $clog2(N_DESC),
    localparam int SEL_W = $clog2(HW_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DESC_W-1:0] cfg_data,
    input  logic              trig_wr,
    input  logic              trig_bit,
    input  logic [HW_N-1:0]   hw_trig,
    input  logic [SEL_W-1:0]  hw_sel,
    output logic              conv_strobe,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_thr_sel,
    output logic              busy
);
    conv_desc_t         cur_desc;
    logic [IDX_W-1:0]   cur_idx;
    logic [MATCH_W-1:0] cnt;
    logic               start, fire, stop, start_req;

    assign start_req = (trig_wr && trig_bit) || hw_trig[hw_sel];

    conv_desc_table #(.N_DESC(N_DESC)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_idx),
        .wdata (conv_desc_t'(cfg_data)),
        .ridx  (cur_idx),
        .rdata (cur_desc)
    );

    conv_pace_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (busy),
        .fire   (fire),
        .reload (cur_desc.clr_timer),
        .stop   (stop),
        .cnt    (cnt)
    );

    conv_seq_ctrl #(.N_DESC(N_DESC)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_req    (start_req),
        .desc         (cur_desc),
        .cnt          (cnt),
        .start        (start),
        .fire         (fire),
        .stop         (stop),
        .idx          (cur_idx),
        .busy         (busy),
        .conv_strobe  (conv_strobe),
        .conv_chan    (conv_chan),
        .conv_thr_sel (conv_thr_sel)
    );

    // R2/R3: an idle block with a trigger is running on the next cycle
    a_r2_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_req |=> busy);
endmodule

// File: tb/conv_sequencer_tb.sv
`timescale 1ns/1ps
module conv_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [13:0] cfg_data = '0;
    logic        trig_wr = 1'b0;
    logic        trig_bit = 1'b0;
    logic [3:0]  hw_trig = '0;
    logic [1:0]  hw_sel = '0;
    logic        conv_strobe;
    logic [2:0]  conv_chan;
    logic        conv_thr_sel;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    conv_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .trig_wr(trig_wr), .trig_bit(trig_bit),
        .hw_trig(hw_trig), .hw_sel(hw_sel), .conv_strobe(conv_strobe),
        .conv_chan(conv_chan), .conv_thr_sel(conv_thr_sel), .busy(busy)
    );

    typedef struct packed {
        logic [7:0] m;
        logic [2:0] ch;
        logic       thr;
        logic [7:0] lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  3'd5, 1'b1, 8'd1},
        '{8'd1,  3'd2, 1'b0, 8'd1},
        '{8'd2,  3'd7, 1'b1, 8'd2},
        '{8'd5,  3'd3, 1'b0, 8'd5},
        '{8'd5,  3'd3, 1'b1, 8'd5},
        '{8'd16, 3'd1, 1'b1, 8'd16},
        '{8'd37, 3'd6, 1'b0, 8'd37}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [13:0] dword(input int ch, input int m, input bit adv,
                                          input bit clr, input bit thr);
        return {3'(ch), 8'(m), adv, clr, thr};
    endfunction

    task automatic wr_desc(input int i, input logic [13:0] d);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sw_trig(input bit b);
        trig_wr = 1'b1; trig_bit = b;
        @(negedge clk);
        trig_wr = 1'b0; trig_bit = 1'b0;
    endtask

    task automatic wait_strobe(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!conv_strobe && k < 600);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k;
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        check(conv_strobe == 1'b0, "R11 strobe", conv_strobe, 0);
        check(busy == 1'b0, "R11 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: table cleared: entry 0 is match 0 halt, fires once at delay 1 on chan 0
        sw_trig(1'b1);
        wait_strobe(k);
        check(k == 1 && conv_chan == 3'd0, "R11 empty entry", k, 1);

        // Vector table: single halting descriptor, R1 R4 R8 R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_desc(0, dword(VECS[v].ch, VECS[v].m, 1'b0, 1'b1, VECS[v].thr));
            sw_trig(1'b1);
            wait_strobe(k);
            check(k == int'(VECS[v].lat), "R4 R9 latency", k, int'(VECS[v].lat));
            check(conv_chan == VECS[v].ch, "R1 R8 chan", conv_chan, VECS[v].ch);
            check(conv_thr_sel == VECS[v].thr, "R8 thr", conv_thr_sel, VECS[v].thr);
            check(busy == 1'b0, "R7 halt busy", busy, 0);
            @(negedge clk);
            check(conv_strobe == 1'b0, "R8 one cycle", conv_strobe, 0);
        end

        // R2: trigger write with bit clear does nothing
        sw_trig(1'b0);
        check(busy == 1'b0, "R2 bit clear", busy, 0);

        // R3: only the selected hardware input starts
        wr_desc(0, dword(4, 2, 1'b0, 1'b1, 1'b0));
        hw_sel = 2'd2;
        @(negedge clk);
        hw_trig = 4'b1011;
        @(negedge clk);
        hw_trig = 4'b0000;
        check(busy == 1'b0, "R3 unselected", busy, 0);
        hw_trig = 4'b0100;
        @(negedge clk);
        hw_trig = 4'b0000;
        check(busy == 1'b1, "R3 selected", busy, 1);
        wait_strobe(k);
        check(k == 2 && conv_chan == 3'd4, "R3 strobe delay", k, 2);

        // R10: triggers during a run are ignored
        @(negedge clk);
        wr_desc(0, dword(3, 20, 1'b0, 1'b1, 1'b0));
        sw_trig(1'b1);
        k = 0;
        do begin
            if (k == 10) begin
                trig_wr = 1'b1; trig_bit = 1'b1; hw_trig = 4'b1111;
            end else begin
                trig_wr = 1'b0; trig_bit = 1'b0; hw_trig = 4'b0000;
            end
            @(negedge clk);
            k++;
        end while (!conv_strobe && k < 600);
        trig_wr = 1'b0; trig_bit = 1'b0; hw_trig = 4'b0000;
        check(k == 20, "R10 timing kept", k, 20);
        @(negedge clk);
        check(busy == 1'b0, "R10 still halts", busy, 0);

        // R6: clear flag off, match values are absolute times 3 then 7
        wr_desc(0, dword(1, 3, 1'b1, 1'b0, 1'b0));
        wr_desc(1, dword(2, 7, 1'b0, 1'b0, 1'b1));
        sw_trig(1'b1);
        wait_strobe(k);
        check(k == 3 && conv_chan == 3'd1, "R6 first no-clear", k, 3);
        wait_strobe(k);
        check(k == 4 && conv_chan == 3'd2, "R6 second at 7", k, 4);

        // R5: match 0 chain gives back-to-back strobes
        @(negedge clk);
        for (int i = 0; i < 3; i++) wr_desc(i, dword(i, 0, 1'b1, 1'b1, 1'b0));
        wr_desc(3, dword(3, 0, 1'b0, 1'b1, 1'b0));
        sw_trig(1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(conv_strobe == 1'b1 && conv_chan == 3'(i), "R5 every cycle", conv_chan, i);
        end
        @(negedge clk);
        check(conv_strobe == 1'b0 && busy == 1'b0, "R5 end", conv_strobe, 0);

        // R6 R7: periodic spacing with clear flag and wrap 7 -> 0
        for (int i = 0; i < 8; i++) wr_desc(i, dword(i, 4, 1'b1, 1'b1, i[0]));
        sw_trig(1'b1);
        for (int j = 0; j < 10; j++) begin
            wait_strobe(k);
            check(k == 4, "R6 spacing", k, 4);
            check(conv_chan == 3'(j % 8), "R7 wrap order", conv_chan, j % 8);
        end
        do_reset();
        check(conv_strobe == 1'b0 && busy == 1'b0, "R11 after reset", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule